// File: doc/BRIEF.md
# Embedded Controller Host Mailbox

This block is the controller side of a two-port byte mailbox. A host reaches it over a byte-wide I/O bus with an address, a read strobe, a write strobe, write data and read data. One offset carries data bytes in both directions. A second offset returns a status byte when read and takes a command byte when written. The host gives a command, then an address byte, and for writes a data byte. It paces itself by polling two handshake flags. One flag says the controller still holds an unread host byte. The other says a reply byte is waiting for the host.

Behind the mailbox sits a 256-entry byte register space. The block reaches it through a plain backend port. A read strobe has its data returned combinationally in the same cycle. A write strobe is taken at the next clock edge. Besides read and write, the block decodes commands that switch a burst flag on and off, and a query command. The query answers 0x00 because no event source is in scope. A host byte is consumed on the clock edge after it arrives, so the input flag never stays up longer than one cycle. This is far inside any polling budget the host keeps.

Top module: `ec_host_if`

## Requirements
- R1: After reset the status byte reads 0x00, the data offset reads 0x00, and neither backend strobe is active.
- R2: Offset 0 is the data port and offset 4 is the status (read) / command (write) port. Any other offset reads 0x00, and a write to it changes no flag.
- R3: Status byte layout: bit 0 means a reply byte waits for the host, bit 1 means an unconsumed host byte, bit 3 means the last host byte was a command, and bit 4 means burst mode. Bits 2, 5, 6 and 7 read 0.
- R4: A host write to offset 0 or 4 sets status bit 1 at that clock edge, and the next clock edge clears it, unless another host write is taken at that edge.
- R5: Status bit 3 becomes 1 after a write to offset 4 and 0 after a write to offset 0.
- R6: Read sequence: command 0x80 followed by an address byte. On the edge after the address write is taken, the block drives the backend read strobe for exactly one cycle with that address. On the edge after that, the returned byte appears at offset 0 and status bit 0 sets.
- R7: Write sequence: command 0x81, an address byte, then a data byte. On the edge after the data byte is taken, the block drives the backend write strobe for exactly one cycle, with that address and data.
- R8: A host read of offset 0 clears status bit 0 at that edge. A read of offset 4 leaves every flag unchanged.
- R9: Command 0x82 sets status bit 4 and command 0x83 clears it. Neither touches the backend or bit 0.
- R10: Command 0x84 loads 0x00 into the data port and sets status bit 0 on the edge after the command is taken.
- R11: A command byte written while a read or write sequence is waiting for bytes abandons that sequence. The bytes that follow are decoded under the new command.
- R12: An unknown command code, or a data byte with no sequence pending, causes no backend strobe and leaves status bit 0 and the data port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 3 | Host port offset |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Byte for the offset on io_addr (combinational) |
| be_addr | output | 8 | Backend register address |
| be_re | output | 1 | Backend read strobe |
| be_we | output | 1 | Backend write strobe |
| be_wdata | output | 8 | Backend write byte |
| be_rdata | input | 8 | Backend read byte, valid in the cycle be_re is high |

## Verification
A wrong sequencer state shows up at the backend port within two cycles of the next host byte. The bench sees a strobe that should not fire, a missing strobe, or a wrong address. The bench compares be_addr and the strobes on the exact cycle. A flag fault shows up in the status byte one edge after the causing access. A stuck input flag or a lost reply flag therefore shows up at the very next poll. Corrupted addressing or data paths show up as mismatches when a reference copy of the register space is read back after random writes.

// File: rtl/ec_host_pkg.sv
package ec_host_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_READ   = 8'h80;
    localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h81;
    localparam logic [BYTE_W-1:0] OP_BURST1 = 8'h82;
    localparam logic [BYTE_W-1:0] OP_BURST0 = 8'h83;
    localparam logic [BYTE_W-1:0] OP_QUERY  = 8'h84;

    localparam logic [BYTE_W-1:0] QUERY_NONE = 8'h00;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RD_ADDR,
        SQ_RD_FETCH,
        SQ_WR_ADDR,
        SQ_WR_DATA
    } seq_state_e;

    typedef struct packed {
        seq_state_e        state;
        logic [BYTE_W-1:0] inbyte;
        logic              in_full;
        logic              was_cmd;
        logic [BYTE_W-1:0] outbyte;
        logic              out_full;
        logic              burst;
        logic [BYTE_W-1:0] reg_addr;
        logic [BYTE_W-1:0] reg_wdata;
        logic              reg_re;
        logic              reg_we;
    } seq_regs_t;

endpackage

// File: rtl/ec_port_decode.sv
module ec_port_decode #(
    parameter int ADDR_W   = 3,
    parameter int DATA_OFS = 0,
    parameter int STAT_OFS = 4
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic              sel_data,
    output logic              sel_stat,
    output logic              data_wr,
    output logic              cmd_wr,
    output logic              data_rd
);

    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    always_comb begin
        sel_data = (io_addr == DATA_A);
        sel_stat = (io_addr == STAT_A);
        data_wr  = io_wr && sel_data;
        cmd_wr   = io_wr && sel_stat;
        data_rd  = io_rd && sel_data;
    end

    initial begin
        assert (DATA_OFS != STAT_OFS)
            else $error("data and status offsets must differ");
    end

endmodule

// File: rtl/ec_status_fmt.sv
module ec_status_fmt #(
    parameter int BYTE_W = 8
) (
    input  logic              sel_data,
    input  logic              sel_stat,
    input  logic              out_full,
    input  logic              in_full,
    input  logic              was_cmd,
    input  logic              burst,
    input  logic [BYTE_W-1:0] outbyte,
    output logic [BYTE_W-1:0] rdata
);

    localparam int BIT_OUT   = 0;
    localparam int BIT_IN    = 1;
    localparam int BIT_CMD   = 3;
    localparam int BIT_BURST = 4;

    logic [BYTE_W-1:0] status_b;

    always_comb begin
        status_b            = '0;
        status_b[BIT_OUT]   = out_full;
        status_b[BIT_IN]    = in_full;
        status_b[BIT_CMD]   = was_cmd;
        status_b[BIT_BURST] = burst;
        if (sel_data) begin
            rdata = outbyte;
        end else if (sel_stat) begin
            rdata = status_b;
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/ec_cmd_seq.sv
module ec_cmd_seq
    import ec_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic              cmd_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [BYTE_W-1:0] be_rdata,
    output logic              in_full,
    output logic              was_cmd,
    output logic              out_full,
    output logic              burst,
    output logic [BYTE_W-1:0] outbyte,
    output logic [BYTE_W-1:0] be_addr,
    output logic [BYTE_W-1:0] be_wdata,
    output logic              be_re,
    output logic              be_we
);

    seq_regs_t r_q, r_d;
    logic      host_wr;

    assign host_wr = data_wr || cmd_wr;

    always_comb begin
        r_d        = r_q;
        r_d.reg_re = 1'b0;
        r_d.reg_we = 1'b0;

        if (data_rd) begin
            r_d.out_full = 1'b0;
        end

        if (r_q.state == SQ_RD_FETCH) begin
            r_d.outbyte  = be_rdata;
            r_d.out_full = 1'b1;
            r_d.state    = SQ_IDLE;
        end

        if (r_q.in_full) begin
            r_d.in_full = 1'b0;
            if (r_q.was_cmd) begin
                r_d.state = SQ_IDLE;
                case (r_q.inbyte)
                    OP_READ:   r_d.state = SQ_RD_ADDR;
                    OP_WRITE:  r_d.state = SQ_WR_ADDR;
                    OP_BURST1: r_d.burst = 1'b1;
                    OP_BURST0: r_d.burst = 1'b0;
                    OP_QUERY: begin
                        r_d.outbyte  = QUERY_NONE;
                        r_d.out_full = 1'b1;
                    end
                    default: ;
                endcase
            end else begin
                case (r_q.state)
                    SQ_RD_ADDR: begin
                        r_d.reg_addr = r_q.inbyte;
                        r_d.reg_re   = 1'b1;
                        r_d.state    = SQ_RD_FETCH;
                    end
                    SQ_WR_ADDR: begin
                        r_d.reg_addr = r_q.inbyte;
                        r_d.state    = SQ_WR_DATA;
                    end
                    SQ_WR_DATA: begin
                        r_d.reg_wdata = r_q.inbyte;
                        r_d.reg_we    = 1'b1;
                        r_d.state     = SQ_IDLE;
                    end
                    default: ;
                endcase
            end
        end

        if (host_wr) begin
            r_d.inbyte  = wbyte;
            r_d.in_full = 1'b1;
            r_d.was_cmd = cmd_wr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: SQ_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_full  = r_q.in_full;
    assign was_cmd  = r_q.was_cmd;
    assign out_full = r_q.out_full;
    assign burst    = r_q.burst;
    assign outbyte  = r_q.outbyte;
    assign be_addr  = r_q.reg_addr;
    assign be_wdata = r_q.reg_wdata;
    assign be_re    = r_q.reg_re;
    assign be_we    = r_q.reg_we;

    a_r4_in_full_sets: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> in_full);
    a_r4_in_full_drains: assert property (@(posedge clk) disable iff (!rst_n)
        in_full && !host_wr |=> !in_full);
    a_r5_cmd_marks: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> was_cmd);
    a_r5_data_marks: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !was_cmd);
    a_r6_fetch_fills: assert property (@(posedge clk) disable iff (!rst_n)
        be_re |=> out_full);
    a_r7_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        be_we |=> !be_we);
    a_r7_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(be_re && be_we));
    a_r9_burst_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(burst) |-> $past(in_full && was_cmd));

endmodule

// File: rtl/ec_host_if.sv
module ec_host_if #(
    parameter int ADDR_W   = 3,
    parameter int DATA_OFS = 0,
    parameter int STAT_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic [7:0]        be_addr,
    output logic              be_re,
    output logic              be_we,
    output logic [7:0]        be_wdata,
    input  logic [7:0]        be_rdata
);

    logic       sel_data, sel_stat, data_wr, cmd_wr, data_rd;
    logic       in_full, was_cmd, out_full, burst;
    logic [7:0] outbyte;

    ec_port_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_OFS(DATA_OFS),
        .STAT_OFS(STAT_OFS)
    ) u_decode (
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .sel_data(sel_data),
        .sel_stat(sel_stat),
        .data_wr (data_wr),
        .cmd_wr  (cmd_wr),
        .data_rd (data_rd)
    );

    ec_cmd_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_wr (data_wr),
        .cmd_wr  (cmd_wr),
        .data_rd (data_rd),
        .wbyte   (io_wdata),
        .be_rdata(be_rdata),
        .in_full (in_full),
        .was_cmd (was_cmd),
        .out_full(out_full),
        .burst   (burst),
        .outbyte (outbyte),
        .be_addr (be_addr),
        .be_wdata(be_wdata),
        .be_re   (be_re),
        .be_we   (be_we)
    );

    ec_status_fmt #(.BYTE_W(8)) u_fmt (
        .sel_data(sel_data),
        .sel_stat(sel_stat),
        .out_full(out_full),
        .in_full (in_full),
        .was_cmd (was_cmd),
        .burst   (burst),
        .outbyte (outbyte),
        .rdata   (io_rdata)
    );

    a_r8_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && !be_re && !(in_full && was_cmd) |=> !out_full);
    a_r2_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && !sel_data && !sel_stat && !in_full |=> !in_full);

endmodule

// File: tb/ec_host_if_tb.sv
module ec_host_if_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] io_addr = '0;
    logic       io_rd = 1'b0;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic [7:0] be_addr, be_wdata, be_rdata;
    logic       be_re, be_we;

    logic [7:0] regs  [256];
    logic [7:0] model [256];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ec_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .be_addr(be_addr), .be_re(be_re),
        .be_we(be_we), .be_wdata(be_wdata), .be_rdata(be_rdata)
    );

    assign be_rdata = regs[be_addr];
    always @(posedge clk) if (be_we) regs[be_addr] <= be_wdata;

    function automatic logic [7:0] stat(input bit obf, ibf, cmd, bst);
        return {3'b000, bst, cmd, 1'b0, ibf, obf};
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); io_addr = a; io_rd = 1'b1; #1 d = io_rdata;
        @(negedge clk); io_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        io_addr = a; #1 d = io_rdata;
    endtask

    task automatic ec_write(input logic [7:0] a, input logic [7:0] d);
        bus_wr(3'd4, 8'h81); bus_wr(3'd0, a); bus_wr(3'd0, d);
        repeat (2) @(negedge clk);
        model[a] = d;
    endtask

    task automatic ec_read(input logic [7:0] a, output logic [7:0] d);
        bus_wr(3'd4, 8'h80); bus_wr(3'd0, a);
        repeat (2) @(negedge clk);
        bus_rd(3'd0, d);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v, s;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 256; i++) begin regs[i] = 8'h00; model[i] = 8'h00; end
        repeat (3) @(negedge clk);
        peek(3'd4, s); chk("R1 status", s, 8'h00);
        peek(3'd0, s); chk("R1 data", s, 8'h00);
        chk("R1 strobes", {be_re, be_we}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: stray offset
        bus_wr(3'd2, 8'h81);
        peek(3'd4, s); chk("R2 stray write no flag", s, 8'h00);
        peek(3'd2, s); chk("R2 stray read zero", s, 8'h00);

        // R3/R4/R5: flags after a command write
        bus_wr(3'd4, 8'h55);
        peek(3'd4, s); chk("R4 R5 in-full and cmd", s, stat(0, 1, 1, 0));
        @(negedge clk);
        peek(3'd4, s); chk("R4 in-full drains", s, stat(0, 0, 1, 0));
        chk("R12 unknown no strobe", {be_re, be_we}, 2'b00);

        // R12: stray data byte with no sequence
        bus_wr(3'd0, 8'h3c);
        peek(3'd4, s); chk("R5 data marks", s, stat(0, 1, 0, 0));
        @(negedge clk);
        chk("R12 stray data no strobe", {be_re, be_we}, 2'b00);
        peek(3'd0, s); chk("R12 data port unchanged", s, 8'h00);

        // R7: directed write timing
        bus_wr(3'd4, 8'h81); bus_wr(3'd0, 8'h12); bus_wr(3'd0, 8'ha5);
        chk("R7 no early strobe", be_we, 1'b0);
        @(negedge clk);
        chk("R7 strobe", {be_we, be_re, be_addr, be_wdata}, {2'b10, 8'h12, 8'ha5});
        @(negedge clk);
        chk("R7 strobe single", be_we, 1'b0);
        model[8'h12] = 8'ha5;

        // R6: directed read timing
        bus_wr(3'd4, 8'h80); bus_wr(3'd0, 8'h12);
        chk("R6 no early read", be_re, 1'b0);
        @(negedge clk);
        chk("R6 read strobe", {be_re, be_addr}, {1'b1, 8'h12});
        peek(3'd4, s); chk("R6 reply not yet", s[0], 1'b0);
        @(negedge clk);
        chk("R6 read single", be_re, 1'b0);
        peek(3'd4, s); chk("R3 R6 reply flag", s, stat(1, 0, 0, 0));
        bus_rd(3'd4, s); bus_rd(3'd4, s);
        chk("R8 status read keeps flag", s[0], 1'b1);
        bus_rd(3'd0, v); chk("R6 data", v, 8'ha5);
        peek(3'd4, s); chk("R8 data read clears", s[0], 1'b0);

        // R9: burst
        bus_wr(3'd4, 8'h82); @(negedge clk);
        peek(3'd4, s); chk("R9 burst on", s, stat(0, 0, 1, 1));
        chk("R9 no backend", {be_re, be_we}, 2'b00);
        bus_wr(3'd4, 8'h83); @(negedge clk);
        peek(3'd4, s); chk("R9 burst off", s, stat(0, 0, 1, 0));

        // R10: query
        bus_wr(3'd4, 8'h84);
        peek(3'd4, s); chk("R10 not yet", s[0], 1'b0);
        @(negedge clk);
        peek(3'd4, s); chk("R10 reply flag", s[0], 1'b1);
        bus_rd(3'd0, v); chk("R10 query zero", v, 8'h00);

        // R11: write aborted by a read command
        bus_wr(3'd4, 8'h81); bus_wr(3'd0, 8'h12);
        bus_wr(3'd4, 8'h80); bus_wr(3'd0, 8'h12);
        @(negedge clk);
        chk("R11 read follows abort", {be_re, be_we, be_addr}, {2'b10, 8'h12});
        @(negedge clk);
        bus_rd(3'd0, v); chk("R11 register intact", v, 8'ha5);
        bus_wr(3'd4, 8'h80);
        bus_wr(3'd4, 8'h81); bus_wr(3'd0, 8'h40); bus_wr(3'd0, 8'h77);
        @(negedge clk);
        chk("R11 write follows abort", {be_we, be_addr, be_wdata}, {1'b1, 8'h40, 8'h77});
        @(negedge clk);
        model[8'h40] = 8'h77;

        // Random traffic against the reference register copy
        for (int n = 0; n < 300; n++) begin
            logic [7:0] a, d;
            a = 8'($urandom);
            d = 8'($urandom);
            if ($urandom % 2 == 0) begin
                ec_write(a, d);
            end else begin
                ec_read(a, v);
                chk("R6 R7 random readback", v, model[a]);
            end
        end

        summary();
        $finish;
    end

endmodule